// File: doc/BRIEF.md
# Buffered Gate-Interval Counter

The block measures time intervals on a Gate input by counting active edges of a Source input, with a resolution of 32 bits. It is armed by a level input; once armed, the first qualifying Gate edge opens a measurement, and every later interval boundary copies the running count into a sample register, restarts the count from zero and pushes the sample into a small output FIFO. That FIFO is read through a valid/ready pair. Three measurement modes are supported. Period mode measures between active Gate edges. Semi-period mode measures between any two Gate edges. Pulse-width mode counts Source edges only while Gate is at its active level.

A synchronous counting option suits slow or irregular Source signals. When it is set, both Source and Gate pass through a two-stage synchronizer on the system clock. Each Source pulse then counts once, however long it is held. An interval that saw no Source edge also stores an honest 0. In direct mode the inputs are taken as already synchronous to the clock, and an empty interval produces no sample, so a stale value is never emitted. Synchronous counting is meant for Source rates up to one quarter of the clock frequency.

Top module: `gated_interval_counter`

## Requirements
- R1: With `meas_mode` = 2'b00 (or 2'b11), a sample is the number of Source active edges between two consecutive active Gate edges. The active Gate edge is rising when `gate_fall`=0 and falling when `gate_fall`=1.
- R2: With `meas_mode` = 2'b01, every Gate edge of either polarity ends one interval and begins the next.
- R3: With `meas_mode` = 2'b10, Source edges are counted only while Gate is at its active level (high when `gate_fall`=0, low when `gate_fall`=1). The sample is taken when Gate leaves the active level. Source edges seen while Gate is inactive are ignored.
- R4: The Source counting edge is rising when `src_fall`=0 and falling when `src_fall`=1.
- R5: While `arm` is low nothing is counted and no sample is produced. After arming, the first interval-opening Gate edge only starts a measurement.
- R6: The count restarts at 0 at every sample. A Source edge detected in the same cycle as an interval boundary belongs to the new interval.
- R7: With `sync_en`=1, Source and Gate pass through two synchronizer flops. A Source pulse held for many clocks counts exactly once.
- R8: An interval with no Source edge pushes a sample of 0 when `sync_en`=1 and pushes nothing when `sync_en`=0.
- R9: Samples leave the FIFO in the order taken. `out_valid` and `out_data` hold steady while `out_ready` is low, and a sample is removed on a clock where both are high.
- R10: A sample taken while the FIFO is full is dropped, and `ovf_err` goes high and stays high until reset.
- R11: After reset `out_valid` and `ovf_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (timebase) |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Level enable for measurement |
| src_in | input | 1 | Source signal to be counted |
| gate_in | input | 1 | Gate signal delimiting intervals |
| meas_mode | input | 2 | 00 period, 01 semi-period, 10 pulse width, 11 as period |
| src_fall | input | 1 | Count falling Source edges when high |
| gate_fall | input | 1 | Gate active edge falling / active level low when high |
| sync_en | input | 1 | Synchronous (duplicate-free) counting |
| out_ready | input | 1 | Consumer accepts the head sample |
| out_valid | output | 1 | FIFO holds at least one sample |
| out_data | output | CNT_W | Head sample |
| ovf_err | output | 1 | Sticky FIFO overflow flag |

## Verification
Two events can fall in the same clock: an interval boundary, where the count is latched and cleared, and a Source increment. The bench provokes this by changing Gate and Source on the same clock edge in period mode. Both signals pass through the same number of stages, so they are detected in the same cycle. The result is judged from two samples: the closed interval must exclude the coincident edge, and the following interval must include it. Overflow is a second coincidence, where a new sample meets a full FIFO; it is judged by the sticky flag and by the surviving samples.

// File: rtl/gic_pkg.sv
package gic_pkg;

  typedef enum logic [1:0] {
    MM_PERIOD = 2'b00,
    MM_SEMI   = 2'b01,
    MM_WIDTH  = 2'b10,
    MM_ALT    = 2'b11
  } meas_mode_e;

  // A latched count is worth storing unless it is empty in direct mode.
  function automatic logic keep_sample(input logic is_zero, input logic sync_mode);
    return sync_mode || !is_zero;
  endfunction

  // Edge that marks Gate entering its active level.
  function automatic logic gate_lead(input logic rise, input logic fall, input logic low_active);
    return low_active ? fall : rise;
  endfunction

  // Edge that marks Gate leaving its active level.
  function automatic logic gate_trail(input logic rise, input logic fall, input logic low_active);
    return low_active ? rise : fall;
  endfunction

endpackage

// File: rtl/gic_edge_sync.sv
module gic_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_en,
  input  logic sig_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  localparam int SW = (STAGES < 2) ? 2 : STAGES;

  logic [SW-1:0] chain;
  logic          sel;
  logic          prev;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[SW-2:0], sig_in};
  end

  assign sel = sync_en ? chain[SW-1] : sig_in;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= sel;
  end

  assign lvl  = sel;
  assign rise = sel & ~prev;
  assign fall = ~sel & prev;
endmodule

// File: rtl/gic_interval.sv
module gic_interval
  import gic_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [1:0]       mode,
  input  logic             gate_fall,
  input  logic             sync_en,
  input  logic             g_lvl,
  input  logic             g_rise,
  input  logic             g_fall,
  input  logic             s_edge,
  output logic             smp_push,
  output logic [CNT_W-1:0] smp_data
);
  meas_mode_e       mm;
  logic             act_lvl, lead_ev, trail_ev;
  logic             open_ev, close_ev, count_en;
  logic             started;
  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] restart_value(input logic inc_now, input logic width_mode);
    return (inc_now && !width_mode) ? CNT_W'(1) : '0;
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  assign mm       = meas_mode_e'(mode);
  assign act_lvl  = g_lvl ^ gate_fall;
  assign lead_ev  = gate_lead(g_rise, g_fall, gate_fall);
  assign trail_ev = gate_trail(g_rise, g_fall, gate_fall);

  always_comb begin
    case (mm)
      MM_SEMI:  begin open_ev = g_rise | g_fall; close_ev = g_rise | g_fall; end
      MM_WIDTH: begin open_ev = lead_ev;         close_ev = trail_ev;        end
      default:  begin open_ev = lead_ev;         close_ev = lead_ev;         end
    endcase
    count_en = s_edge && ((mm != MM_WIDTH) || act_lvl);
  end

  always_ff @(posedge clk) begin
    if (rst || !arm) begin
      started  <= 1'b0;
      cnt      <= '0;
      smp_push <= 1'b0;
      smp_data <= '0;
    end else begin
      smp_push <= 1'b0;
      if (started && close_ev) begin
        smp_push <= keep_sample(cnt == '0, sync_en);
        smp_data <= cnt;
        cnt      <= restart_value(count_en, mm == MM_WIDTH);
      end else if (!started && open_ev) begin
        started <= 1'b1;
        cnt     <= count_en ? CNT_W'(1) : '0;
      end else if (started && count_en) begin
        cnt <= bump(cnt);
      end
    end
  end
endmodule

// File: rtl/gic_fifo.sv
module gic_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop_ready,
  output logic             valid,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             ovf
);
  localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wp, rp;
  logic             pop, wr;

  assign valid = (wp != rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign pop   = valid && pop_ready;
  assign wr    = push && !full;
  assign dout  = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      ovf <= 1'b0;
    end else begin
      if (wr)  wp <= wp + 1'b1;
      if (pop) rp <= rp + 1'b1;
      if (push && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/gated_interval_counter.sv
module gated_interval_counter #(
  parameter int CNT_W       = 32,
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             src_in,
  input  logic             gate_in,
  input  logic [1:0]       meas_mode,
  input  logic             src_fall,
  input  logic             gate_fall,
  input  logic             sync_en,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [CNT_W-1:0] out_data,
  output logic             ovf_err
);
  logic             g_lvl, g_rise, g_fall;
  logic             s_lvl, s_rise, s_fall, s_edge;
  logic             smp_push, fifo_full;
  logic [CNT_W-1:0] smp_data;

  gic_edge_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst(rst), .sync_en(sync_en), .sig_in(gate_in),
    .lvl(g_lvl), .rise(g_rise), .fall(g_fall)
  );

  gic_edge_sync #(.STAGES(SYNC_STAGES)) u_src_sync (
    .clk(clk), .rst(rst), .sync_en(sync_en), .sig_in(src_in),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  assign s_edge = src_fall ? s_fall : s_rise;

  gic_interval #(.CNT_W(CNT_W)) u_interval (
    .clk(clk), .rst(rst), .arm(arm), .mode(meas_mode), .gate_fall(gate_fall),
    .sync_en(sync_en), .g_lvl(g_lvl), .g_rise(g_rise), .g_fall(g_fall),
    .s_edge(s_edge), .smp_push(smp_push), .smp_data(smp_data)
  );

  gic_fifo #(.WIDTH(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(smp_push), .din(smp_data),
    .pop_ready(out_ready), .valid(out_valid), .dout(out_data),
    .full(fifo_full), .ovf(ovf_err)
  );

  logic unused_lvl;
  assign unused_lvl = s_lvl;
endmodule

// File: rtl/gic_checker.sv
module gic_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             arm,
  input logic             sync_en,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CNT_W-1:0] out_data,
  input logic             ovf_err,
  input logic             smp_push,
  input logic [CNT_W-1:0] smp_data,
  input logic             fifo_full
);
  p_disarm_r5: assert property (@(posedge clk) disable iff (rst)
    !arm |=> !smp_push);

  p_no_empty_direct_r8: assert property (@(posedge clk) disable iff (rst)
    (smp_push && !sync_en) |-> (smp_data != '0));

  p_hold_head_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    (smp_push && fifo_full) |=> ovf_err);

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);

  p_reset_state_r11: assert property (@(posedge clk)
    rst |=> (!out_valid && !ovf_err));
endmodule

bind gated_interval_counter gic_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .arm(arm), .sync_en(sync_en),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .ovf_err(ovf_err), .smp_push(smp_push), .smp_data(smp_data),
  .fifo_full(fifo_full)
);

// File: tb/gated_interval_counter_bench.sv
module gated_interval_counter_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         arm = 1'b0;
  logic         src_in = 1'b0;
  logic         gate_in = 1'b0;
  logic [1:0]   meas_mode = 2'b00;
  logic         src_fall = 1'b0;
  logic         gate_fall = 1'b0;
  logic         sync_en = 1'b0;
  logic         out_ready = 1'b0;
  logic         out_valid;
  logic [W-1:0] out_data;
  logic         ovf_err;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  gated_interval_counter u_gated_interval_counter (
    .clk(clk), .rst(rst), .arm(arm), .src_in(src_in), .gate_in(gate_in),
    .meas_mode(meas_mode), .src_fall(src_fall), .gate_fall(gate_fall),
    .sync_en(sync_en), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .ovf_err(ovf_err)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_val(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse();
    src_in = 1'b1; step(2);
    src_in = 1'b0; step(2);
  endtask

  task automatic gate_on();
    gate_in = !gate_fall; step(3);
  endtask

  task automatic gate_off();
    gate_in = gate_fall; step(3);
  endtask

  task automatic configure(input logic [1:0] m, input logic gf, input logic sf, input logic sy);
    arm = 1'b0; step(1);
    meas_mode = m; gate_fall = gf; src_fall = sf; sync_en = sy;
    src_in = 1'b0; gate_in = gf;
    step(6);
    arm = 1'b1; step(1);
  endtask

  task automatic expect_sample(input string tag, input longint exp);
    step(4);
    check_val({tag, " valid"}, out_valid, 1);
    check_val({tag, " data"}, out_data, exp);
    out_ready = 1'b1; step(1); out_ready = 1'b0;
  endtask

  task automatic expect_none(input string tag);
    step(4);
    check_val({tag, " no sample"}, out_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(4);
    rst = 1'b0; step(1);
    check_val("R11 reset valid", out_valid, 0);
    check_val("R11 reset ovf", ovf_err, 0);

    // R1 period sweep, R8 empty interval handling
    for (int sy = 0; sy < 2; sy++) begin
      for (int gf = 0; gf < 2; gf++) begin
        configure(2'b00, gf[0], 1'b0, sy[0]);
        gate_on();
        expect_none("R5 first edge");
        for (int n = 0; n < 5; n++) begin
          for (int k = 0; k < n; k++) pulse();
          gate_off(); gate_on();
          if (sy == 1 || n > 0) expect_sample("R1 period", n);
          else expect_none("R8 direct empty");
        end
      end
    end

    // R2 semi-period sweep
    for (int sy = 0; sy < 2; sy++) begin
      configure(2'b01, 1'b0, 1'b1, sy[0]);
      gate_in = ~gate_in; step(3);
      expect_none("R5 semi first edge");
      for (int n = 0; n < 5; n++) begin
        for (int k = 0; k < n; k++) pulse();
        gate_in = ~gate_in; step(3);
        if (sy == 1 || n > 0) expect_sample("R2 semi", n);
        else expect_none("R8 semi empty");
      end
    end

    // R3 pulse width: edges while inactive ignored
    for (int gf = 0; gf < 2; gf++) begin
      configure(2'b10, gf[0], 1'b0, gf[0]);
      for (int a = 1; a < 5; a++) begin
        gate_on();
        for (int k = 0; k < a; k++) pulse();
        gate_off();
        expect_sample("R3 width", a);
        pulse(); pulse();
        expect_none("R3 inactive ignored");
      end
    end

    // R4 source edge select: pulse straddling a boundary
    for (int sf = 0; sf < 2; sf++) begin
      configure(2'b00, 1'b0, sf[0], 1'b1);
      gate_on();
      src_in = 1'b1; step(2);
      gate_off(); gate_on();
      expect_sample("R4 before boundary", sf == 0 ? 1 : 0);
      src_in = 1'b0; step(2);
      gate_off(); gate_on();
      expect_sample("R4 after boundary", sf == 0 ? 0 : 1);
    end

    // R7 long pulse counts once in sync mode
    configure(2'b00, 1'b0, 1'b0, 1'b1);
    gate_on();
    src_in = 1'b1; step(20); src_in = 1'b0; step(2);
    pulse();
    gate_off(); gate_on();
    expect_sample("R7 long pulse once", 2);

    // R6 coincident boundary and source edge
    configure(2'b00, 1'b0, 1'b0, 1'b0);
    gate_on();
    pulse(); pulse();
    gate_off();
    gate_in = 1'b1; src_in = 1'b1; step(2);
    src_in = 1'b0; step(2);
    expect_sample("R6 closed interval", 2);
    gate_off();
    pulse();
    gate_on();
    expect_sample("R6 new interval", 2);

    // R5 disarmed activity is ignored
    configure(2'b00, 1'b0, 1'b0, 1'b1);
    arm = 1'b0; step(1);
    for (int k = 0; k < 3; k++) begin gate_on(); pulse(); gate_off(); end
    expect_none("R5 disarmed");
    arm = 1'b1; step(1);
    gate_on(); pulse(); gate_off(); gate_on();
    expect_sample("R5 rearmed", 1);

    // R10 overflow, R9 ordering
    configure(2'b00, 1'b0, 1'b0, 1'b1);
    gate_on();
    for (int i = 0; i < 5; i++) begin
      for (int k = 0; k <= i; k++) pulse();
      gate_off(); gate_on();
    end
    step(4);
    check_val("R10 overflow flag", ovf_err, 1);
    check_val("R9 held head", out_data, 1);
    for (int i = 0; i < 4; i++) expect_sample("R9 order", i + 1);
    expect_none("R10 dropped sample");
    check_val("R10 sticky", ovf_err, 1);

    rst = 1'b1; step(2); rst = 1'b0; step(1);
    check_val("R11 reset clears valid", out_valid, 0);
    check_val("R11 reset clears ovf", ovf_err, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule